// File: doc/BRIEF.md
# Input Tap Delay Tuning Sweeper

This block picks the input sampling delay for a high-speed card receive path. After a start pulse it turns on the input delay path. It then steps the delay tap through every setting from the lowest to the highest. At each setting it asks an external agent to run one tuning transfer, and it takes back a single pass or fail result. When the sweep is over, it programs the tap at the middle of the passing region and reports that value.

The block keeps no per-tap result table. It keeps three things: the previous result, a running count of failing taps, and the tap at which the most recent fail-to-pass edge was seen. The passing region is taken to be everything that did not fail, starting at that edge and wrapping past the top of the range if needed. Its midpoint is the edge tap plus half the passing length, modulo the tap count.

The delay line is reached through a plain register port that has an enable, a change-window strobe and a tap select. Every change of the select is framed by the strobe. Trials travel over two valid/ready channels:
- The request channel carries the tap under test. Once `req_valid_o` is raised, the request and its tap stay unchanged until the cycle in which `req_ready_i` is high.
- The response channel is only ready while one trial is outstanding. The agent may hold `rsp_valid_i` low for as long as it likes; the block waits.

Top module: `tap_delay_sweeper`

## Requirements
- R1: Out of reset, `busy_o`, `done_o`, `tap_ena_o`, `tap_win_o`, `req_valid_o` and `rsp_ready_o` are 0, and `tap_sel_o` is 0.
- R2: After `start_i`, the delay path enable `tap_ena_o` is set to 1 before the first tap write. It stays at 1 from then on.
- R3: Exactly one trial is requested for each tap, in increasing order from 0 to 31. While a request is pending, `tap_sel_o` already equals `req_tap_o` and the change window is closed.
- R4: A request holds `req_valid_o` and `req_tap_o` stable until `req_ready_i` is seen. `rsp_ready_o` is high only while a trial is outstanding, and never while a request is pending. A result is taken only in a cycle in which both `rsp_valid_i` and `rsp_ready_o` are high. Stalls on either channel do not change the outcome.
- R5: Every tap write takes three separate cycles: the window strobe `tap_win_o` rises, the select changes, and the strobe falls. `tap_sel_o` never changes unless the strobe was high both before and after the change.
- R6: The previous result starts as pass, so a pass at tap 0 does not mark a window start. The window start is the tap at which a pass follows a fail. A later such edge replaces an earlier one, and the start is 0 when no such edge occurs.
- R7: The chosen tap is (start + ((32 − fail count) >> 1)) mod 32. If every tap passes, the chosen tap is 16.
- R8: If every tap fails, `all_fail_o` is 1 and the computed tap 0 is still written. Otherwise `all_fail_o` is 0.
- R9: After the final write closes its window, `done_o` is high for exactly one cycle. `best_tap_o` holds the chosen tap until the next sweep ends, and `tap_sel_o` equals it.
- R10: A `start_i` pulse while `busy_o` is high is ignored. The running sweep still makes exactly 32 requests and raises `done_o` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sweep (ignored while busy) |
| busy_o | output | 1 | Sweep in progress |
| req_valid_o | output | 1 | Trial request valid |
| req_ready_i | input | 1 | Agent accepts the trial request |
| req_tap_o | output | TAP_BITS | Tap under test |
| rsp_valid_i | input | 1 | Trial result valid |
| rsp_ready_o | output | 1 | Block accepts a trial result |
| rsp_pass_i | input | 1 | 1 = trial passed, 0 = failed |
| tap_ena_o | output | 1 | Input delay path enable |
| tap_win_o | output | 1 | Tap change-window strobe |
| tap_sel_o | output | TAP_BITS | Tap select written to the delay line |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| best_tap_o | output | TAP_BITS | Chosen tap, held after a sweep |
| all_fail_o | output | 1 | No tap passed in the last sweep |

## Verification
The search is tried against a single circular passing window at every start position. Several window lengths are used, including lengths 1 and 31, and windows that wrap past tap 31. Together these separate a correct midpoint from off-by-one halving and from a missing modulo. All-pass and all-fail patterns cover the two ends of the fail count. A pass at tap 0 alone, and a pass at taps 0 and 31 only, show whether the previous result starts as pass. A two-window pattern shows whether the last edge wins over the first. Pseudo-random stalls on both channels, and a start pulse in the middle of a sweep, show that handshakes and re-triggering do not disturb the tap order or the outcome.

// File: rtl/tap_sweep_pkg.sv
package tap_sweep_pkg;

  typedef enum logic [2:0] {
    SW_IDLE,
    SW_ARM,
    SW_LAUNCH,
    SW_WRITE,
    SW_REQ,
    SW_RSP
  } sweep_state_t;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_LOAD,
    WR_CLOSE
  } wr_state_t;

endpackage

// File: rtl/tap_step_writer.sv
// Three-step tap write: open the change window, load the select, close the window.
module tap_step_writer
  import tap_sweep_pkg::*;
#(
  parameter int TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go_i,
  input  logic [TAP_BITS-1:0] val_i,
  output logic                win_o,
  output logic [TAP_BITS-1:0] sel_o,
  output logic                fin_o
);

  wr_state_t           st_q;
  logic [TAP_BITS-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      win_o  <= 1'b0;
      sel_o  <= '0;
      hold_q <= '0;
    end else begin
      case (st_q)
        WR_IDLE: begin
          if (go_i) begin
            win_o  <= 1'b1;
            hold_q <= val_i;
            st_q   <= WR_LOAD;
          end
        end
        WR_LOAD: begin
          sel_o <= hold_q;
          st_q  <= WR_CLOSE;
        end
        WR_CLOSE: begin
          win_o <= 1'b0;
          st_q  <= WR_IDLE;
        end
        default: st_q <= WR_IDLE;
      endcase
    end
  end

  // Asserted in the cycle whose closing edge drops the window.
  assign fin_o = (st_q == WR_CLOSE);

endmodule

// File: rtl/tap_window_tracker.sv
// Single-pass passing-window tracker: previous result, fail count, last rising edge.
module tap_window_tracker #(
  parameter int TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear_i,
  input  logic                upd_i,
  input  logic                pass_i,
  input  logic [TAP_BITS-1:0] tap_i,
  output logic [TAP_BITS-1:0] centre_o,
  output logic                all_fail_o
);

  localparam logic [TAP_BITS:0] NUM_TAPS_V = {1'b1, {TAP_BITS{1'b0}}};

  logic                prev_q;
  logic [TAP_BITS-1:0] start_q;
  logic [TAP_BITS:0]   fails_q;
  logic [TAP_BITS:0]   pass_len;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      prev_q  <= 1'b1;
      start_q <= '0;
      fails_q <= '0;
    end else if (upd_i) begin
      if (pass_i && !prev_q) start_q <= tap_i;
      if (!pass_i) fails_q <= fails_q + (TAP_BITS+1)'(1);
      prev_q <= pass_i;
    end
  end

  assign pass_len   = NUM_TAPS_V - fails_q;
  // Truncation to TAP_BITS performs the circular wrap.
  assign centre_o   = start_q + pass_len[TAP_BITS:1];
  assign all_fail_o = (fails_q == NUM_TAPS_V);

endmodule

// File: rtl/tap_sweep_ctrl.sv
// Sequencer: enable, per-tap write / request / response loop, final write.
module tap_sweep_ctrl
  import tap_sweep_pkg::*;
#(
  parameter int TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                fin_i,
  input  logic [TAP_BITS-1:0] centre_i,
  input  logic                all_fail_i,
  input  logic                req_ready_i,
  input  logic                rsp_valid_i,
  output logic                go_o,
  output logic [TAP_BITS-1:0] wr_val_o,
  output logic                clear_o,
  output logic                upd_o,
  output logic                req_valid_o,
  output logic [TAP_BITS-1:0] req_tap_o,
  output logic                rsp_ready_o,
  output logic                tap_ena_o,
  output logic                busy_o,
  output logic                done_o,
  output logic [TAP_BITS-1:0] best_o,
  output logic                err_o
);

  localparam logic [TAP_BITS-1:0] LAST_TAP = '1;

  sweep_state_t        st_q;
  logic [TAP_BITS-1:0] idx_q;
  logic                final_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= SW_IDLE;
      idx_q     <= '0;
      final_q   <= 1'b0;
      tap_ena_o <= 1'b0;
      done_o    <= 1'b0;
      best_o    <= '0;
      err_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st_q)
        SW_IDLE: begin
          if (start_i) st_q <= SW_ARM;
        end
        SW_ARM: begin
          tap_ena_o <= 1'b1;
          idx_q     <= '0;
          final_q   <= 1'b0;
          st_q      <= SW_LAUNCH;
        end
        SW_LAUNCH: st_q <= SW_WRITE;
        SW_WRITE: begin
          if (fin_i) begin
            if (final_q) begin
              done_o <= 1'b1;
              best_o <= centre_i;
              err_o  <= all_fail_i;
              st_q   <= SW_IDLE;
            end else begin
              st_q <= SW_REQ;
            end
          end
        end
        SW_REQ: begin
          if (req_ready_i) st_q <= SW_RSP;
        end
        SW_RSP: begin
          if (rsp_valid_i) begin
            if (idx_q == LAST_TAP) final_q <= 1'b1;
            else idx_q <= idx_q + TAP_BITS'(1);
            st_q <= SW_LAUNCH;
          end
        end
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  assign go_o        = (st_q == SW_LAUNCH);
  assign wr_val_o    = final_q ? centre_i : idx_q;
  assign clear_o     = (st_q == SW_ARM);
  assign upd_o       = (st_q == SW_RSP) && rsp_valid_i;
  assign req_valid_o = (st_q == SW_REQ);
  assign req_tap_o   = idx_q;
  assign rsp_ready_o = (st_q == SW_RSP);
  assign busy_o      = (st_q != SW_IDLE);

endmodule

// File: rtl/tap_delay_sweeper.sv
module tap_delay_sweeper #(
  parameter int TAP_BITS = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  output logic                busy_o,
  output logic                req_valid_o,
  input  logic                req_ready_i,
  output logic [TAP_BITS-1:0] req_tap_o,
  input  logic                rsp_valid_i,
  output logic                rsp_ready_o,
  input  logic                rsp_pass_i,
  output logic                tap_ena_o,
  output logic                tap_win_o,
  output logic [TAP_BITS-1:0] tap_sel_o,
  output logic                done_o,
  output logic [TAP_BITS-1:0] best_tap_o,
  output logic                all_fail_o
);

  logic                go;
  logic                fin;
  logic [TAP_BITS-1:0] wr_val;
  logic                clear;
  logic                upd;
  logic [TAP_BITS-1:0] centre;
  logic                none_pass;

  tap_sweep_ctrl #(.TAP_BITS(TAP_BITS)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fin_i       (fin),
    .centre_i    (centre),
    .all_fail_i  (none_pass),
    .req_ready_i (req_ready_i),
    .rsp_valid_i (rsp_valid_i),
    .go_o        (go),
    .wr_val_o    (wr_val),
    .clear_o     (clear),
    .upd_o       (upd),
    .req_valid_o (req_valid_o),
    .req_tap_o   (req_tap_o),
    .rsp_ready_o (rsp_ready_o),
    .tap_ena_o   (tap_ena_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .best_o      (best_tap_o),
    .err_o       (all_fail_o)
  );

  tap_step_writer #(.TAP_BITS(TAP_BITS)) u_writer (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (go),
    .val_i (wr_val),
    .win_o (tap_win_o),
    .sel_o (tap_sel_o),
    .fin_o (fin)
  );

  tap_window_tracker #(.TAP_BITS(TAP_BITS)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (clear),
    .upd_i      (upd),
    .pass_i     (rsp_pass_i),
    .tap_i      (req_tap_o),
    .centre_o   (centre),
    .all_fail_o (none_pass)
  );

endmodule

// File: rtl/tap_sweep_checker.sv
module tap_sweep_checker #(
  parameter int TAP_BITS = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                busy_o,
  input logic                req_valid_o,
  input logic                req_ready_i,
  input logic [TAP_BITS-1:0] req_tap_o,
  input logic                rsp_ready_o,
  input logic                tap_ena_o,
  input logic                tap_win_o,
  input logic [TAP_BITS-1:0] tap_sel_o,
  input logic                done_o,
  input logic [TAP_BITS-1:0] best_tap_o
);

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_tap_o));

  a_r4_rsp_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready_o |-> !req_valid_o);

  a_r5_sel_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tap_sel_o) |-> tap_win_o && $past(tap_win_o));

  a_r2_ena_before_trial: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> tap_ena_o);

  a_r3_req_tap_written: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (tap_sel_o == req_tap_o) && !tap_win_o);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_done_result: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (tap_sel_o == best_tap_o) && !busy_o && !tap_win_o);

endmodule

bind tap_delay_sweeper tap_sweep_checker #(.TAP_BITS(TAP_BITS)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy_o      (busy_o),
  .req_valid_o (req_valid_o),
  .req_ready_i (req_ready_i),
  .req_tap_o   (req_tap_o),
  .rsp_ready_o (rsp_ready_o),
  .tap_ena_o   (tap_ena_o),
  .tap_win_o   (tap_win_o),
  .tap_sel_o   (tap_sel_o),
  .done_o      (done_o),
  .best_tap_o  (best_tap_o)
);

// File: tb/test_tap_delay_sweeper.sv
module test_tap_delay_sweeper;

  localparam int CLK_PERIOD = 10;
  localparam int NT = 32;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic       busy_o;
  logic       req_valid_o;
  logic       req_ready_i;
  logic [4:0] req_tap_o;
  logic       rsp_valid_i;
  logic       rsp_ready_o;
  logic       rsp_pass_i;
  logic       tap_ena_o;
  logic       tap_win_o;
  logic [4:0] tap_sel_o;
  logic       done_o;
  logic [4:0] best_tap_o;
  logic       all_fail_o;

  tap_delay_sweeper #(.TAP_BITS(5)) i_tap_delay_sweeper (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .req_valid_o (req_valid_o),
    .req_ready_i (req_ready_i),
    .req_tap_o   (req_tap_o),
    .rsp_valid_i (rsp_valid_i),
    .rsp_ready_o (rsp_ready_o),
    .rsp_pass_i  (rsp_pass_i),
    .tap_ena_o   (tap_ena_o),
    .tap_win_o   (tap_win_o),
    .tap_sel_o   (tap_sel_o),
    .done_o      (done_o),
    .best_tap_o  (best_tap_o),
    .all_fail_o  (all_fail_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // Responder / monitor state
  logic [31:0] pat_g = '0;
  logic [15:0] lfsr = 16'hACE1;
  bit          pending = 0;
  int          dly = 0;
  int          cur_tap = 0;
  int          exp_tap = 0;
  int          n_req = 0;
  int          order_err = 0;
  int          win_err = 0;
  int          ena_err = 0;
  int          done_cnt = 0;
  int          done_wide = 0;
  logic        prev_done = 1'b0;
  logic        prev_win = 1'b0;
  logic [4:0]  prev_sel = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (!rst_n) begin
      req_ready_i = 1'b0;
      rsp_valid_i = 1'b0;
      rsp_pass_i  = 1'b0;
      pending     = 0;
    end else begin
      if (tap_sel_o != prev_sel && !(tap_win_o && prev_win)) win_err++;
      if (done_o) begin
        done_cnt++;
        if (prev_done) done_wide++;
      end
      if (req_valid_o && !tap_ena_o) ena_err++;
      // response channel
      if (pending && dly > 0) dly--;
      rsp_valid_i = pending && (dly == 0);
      rsp_pass_i  = pending ? pat_g[cur_tap] : 1'b0;
      if (rsp_valid_i && rsp_ready_o) pending = 0;
      // request channel, with pseudo-random stalls
      req_ready_i = lfsr[0] | lfsr[3];
      if (req_valid_o && req_ready_i) begin
        if (int'(req_tap_o) != exp_tap) order_err++;
        exp_tap++;
        n_req++;
        pending = 1;
        cur_tap = int'(req_tap_o);
        dly     = int'(lfsr[5:4]);
      end
    end
    prev_sel  = tap_sel_o;
    prev_win  = tap_win_o;
    prev_done = done_o;
  end

  function automatic logic [31:0] win_mask(input int s, input int len);
    logic [31:0] m;
    for (int t = 0; t < NT; t++) m[t] = (((t - s + NT) % NT) < len);
    return m;
  endfunction

  task automatic run_case(input logic [31:0] pat, input int exp_best,
                          input bit exp_err, input string req, input bit poke);
    int cyc;
    pat_g     = pat;
    n_req     = 0;
    order_err = 0;
    win_err   = 0;
    ena_err   = 0;
    done_cnt  = 0;
    done_wide = 0;
    exp_tap   = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    cyc = 0;
    while (done_cnt == 0 && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      start_i = (poke && cyc == 50);
    end
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    check(done_cnt == 1, poke ? "R10" : "R9", "done pulses", done_cnt, 1);
    check(done_wide == 0, "R9", "done width>1", done_wide, 0);
    check(n_req == NT, poke ? "R10" : "R3", "trial count", n_req, NT);
    check(order_err == 0, "R4", "tap order under stalls", order_err, 0);
    check(win_err == 0, "R5", "select change outside window", win_err, 0);
    check(ena_err == 0 && tap_ena_o, "R2", "enable before trials", int'(tap_ena_o), 1);
    check(int'(best_tap_o) == exp_best, req, "best tap", int'(best_tap_o), exp_best);
    check(all_fail_o == exp_err, "R8", "all-fail flag", int'(all_fail_o), int'(exp_err));
    check(tap_sel_o == best_tap_o && !tap_win_o, "R9", "final tap written",
          int'(tap_sel_o), int'(best_tap_o));
    check(!busy_o, "R9", "idle after done", int'(busy_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: sweep run hung (R9 done never seen) actual 0 expected 1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!busy_o && !done_o && !req_valid_o && !rsp_ready_o, "R1", "idle flags",
          int'({busy_o, done_o, req_valid_o, rsp_ready_o}), 0);
    check(!tap_ena_o && !tap_win_o && tap_sel_o == 0, "R1", "tap port",
          int'({tap_ena_o, tap_win_o, tap_sel_o}), 0);

    // R7: all pass gives tap 16
    run_case(32'hFFFF_FFFF, 16, 1'b0, "R7", 1'b0);
    // R8: all fail gives tap 0 and flag
    run_case(32'h0000_0000, 0, 1'b1, "R8", 1'b0);
    // R6: pass at tap 0 alone is not a window start
    run_case(32'h0000_0001, 0, 1'b0, "R6", 1'b0);
    // R6: taps 31 and 0 pass, start 31, len 2 -> 0
    run_case(32'h8000_0001, 0, 1'b0, "R6", 1'b0);
    // R6: windows 3..6 and 20..29, last edge 20, len 14 -> 27
    run_case(win_mask(3, 4) | win_mask(20, 10), 27, 1'b0, "R6", 1'b0);
    // R10: start pulse mid-sweep ignored
    run_case(win_mask(9, 6), 12, 1'b0, "R10", 1'b1);
    // R7: every start position, several lengths
    for (int s = 0; s < NT; s++) begin
      for (int k = 0; k < 5; k++) begin
        int len;
        case (k)
          0: len = 1;
          1: len = 2;
          2: len = 7;
          3: len = 16;
          default: len = 31;
        endcase
        run_case(win_mask(s, len), (s + len / 2) % NT, 1'b0, "R7", 1'b0);
      end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule